// File: doc/BRIEF.md
# Video Timing Counter Synchronizer

This block holds the time base of a TV-style video encoder: a horizontal counter that steps in half-pixel units, a vertical counter that steps in half-line units, and a one-bit field indicator that tells the odd (first) field from the even (second) one. With no synchronization event the counters run free. The horizontal counter wraps once per line and the vertical counter wraps once per frame.

When the format select picks one of the two embedded-synchronization formats, the block takes the F and H flags that an upstream decoder pulls out of the stream's timing reference codes, along with a strobe that marks each flag sample as valid. A low-to-high change of H reloads the horizontal counter from a programmable horizontal trigger value. A low-to-high change of F reloads the vertical counter from a programmable vertical trigger value and marks the even field. The two trigger values set the phase of the output image against the input image. The block drives out the counter values and two strobes, one for line start and one for field start, for the encoder stages that follow it.

Top module: `tv_timebase_sync`

## Requirements
- R1: While `rstN` is low, `hCount` and `vCount` are 0, `fieldEven` is 0 (odd field), and the flag history is cleared to low.
- R2: With no H load, `hCount` rises by 1 on each clock. When it is greater than or equal to 2*`pixPerLine`-1, it returns to 0 on the next clock. `pixPerLine` must be at least 1.
- R3: Each horizontal wrap (R2) that occurs without an F load adds 2 to `vCount`. In all other cycles without an F load, `vCount` holds its value.
- R4: If a horizontal wrap would bring `vCount`+2 to or above `halfLinesPerFrame`, `vCount` becomes 0 and `fieldEven` inverts. Otherwise `fieldEven` changes only through R6.
- R5: Embedded synchronization is on only when `fmtSel` is 4'b1100 or 4'b1101. For any other value, F and H changes have no effect on the counters or the field.
- R6: An F rise (R8) reloads `vCount` with `vTrig` and sets `fieldEven` to 1 on the next clock. It takes priority over the vertical step and wrap in the same cycle.
- R7: An H rise (R8) reloads `hCount` with `hTrig` on the next clock. No horizontal wrap and no vertical step happens in that cycle.
- R8: A rise means a sample with `flagValid` high where the flag is 1 and the previous valid sample of that flag was 0. A flag held high produces only one rise. Samples taken while `flagValid` is low neither cause a rise nor update the history.
- R9: `lineStart` is high exactly while `hCount` is 0. `fieldStart` is high exactly while both `hCount` and `vCount` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| fmtSel | input | 4 | Input format select; 4'b1100 and 4'b1101 turn on embedded synchronization |
| pixPerLine | input | PIX_W | Pixels per line |
| halfLinesPerFrame | input | V_W | Vertical wrap limit in half-lines |
| hTrig | input | PIX_W+1 | Horizontal reload value in half-pixels |
| vTrig | input | V_W | Vertical reload value in half-lines |
| flagValid | input | 1 | Marks fFlag and hFlag as a valid sample |
| fFlag | input | 1 | Field flag from the timing reference codes |
| hFlag | input | 1 | Horizontal flag from the timing reference codes |
| hCount | output | PIX_W+1 | Horizontal position in half-pixels |
| vCount | output | V_W | Vertical position in half-lines |
| fieldEven | output | 1 | 1 during the even (second) field |
| lineStart | output | 1 | High while hCount is 0 |
| fieldStart | output | 1 | High while hCount and vCount are both 0 |

## Verification
The bound checker checks on every cycle what happens after each control strobe. A horizontal load produces the trigger value, a step adds one and a wrap produces zero. A vertical load sets the even field, a vertical wrap clears the count and inverts the field, and the vertical count holds between line wraps. The checker also confirms that no load is raised outside the embedded formats and that field start never occurs away from a line start. Only the bench's scenarios can show that the loads come from the right flag transitions: a flag held high, samples with the valid strobe low, switches of format, and trigger values at the end of the line. Those depend on flag history that spans many cycles, so the bench compares against its behavioural model on every clock.

// File: rtl/vtsync_pkg.sv
package vtsync_pkg;

  localparam int NUM_FLAGS = 2;
  localparam int FLAG_H    = 0;
  localparam int FLAG_F    = 1;

  localparam logic [3:0] FMT_EMB_A = 4'b1100;
  localparam logic [3:0] FMT_EMB_B = 4'b1101;

  // Strobes from control to datapath for one clock
  typedef struct packed {
    logic hLoad;   // reload horizontal counter from trigger
    logic hWrap;   // horizontal counter returns to zero
    logic vLoad;   // reload vertical counter, mark even field
    logic vWrap;   // vertical counter returns to zero, field flips
    logic vStep;   // vertical counter advances by two half-lines
  } syncCtrl_t;

  function automatic logic isEmbeddedFmt(input logic [3:0] fmt);
    return (fmt == FMT_EMB_A) || (fmt == FMT_EMB_B);
  endfunction

endpackage

// File: rtl/vtsync_flag_edge.sv
module vtsync_flag_edge #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         sampleEn,
  input  logic [N-1:0] flags,
  output logic [N-1:0] rise
);

  logic [N-1:0] prevFlags;

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevFlags[i] <= 1'b0;
      end else if (sampleEn) begin
        prevFlags[i] <= flags[i];
      end
    end

    assign rise[i] = sampleEn & flags[i] & ~prevFlags[i];
  end

endmodule

// File: rtl/vtsync_ctrl.sv
module vtsync_ctrl
  import vtsync_pkg::*;
#(
  parameter  int PIX_W = 10,
  parameter  int V_W   = 11,
  localparam int HC_W  = PIX_W + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [3:0]      fmtSel,
  input  logic [PIX_W-1:0] pixPerLine,
  input  logic [V_W-1:0]  halfLinesPerFrame,
  input  logic            flagValid,
  input  logic            fFlag,
  input  logic            hFlag,
  input  logic [HC_W-1:0] hCount,
  input  logic [V_W-1:0]  vCount,
  output syncCtrl_t       ctrl
);

  logic [NUM_FLAGS-1:0] flagVec;
  logic [NUM_FLAGS-1:0] flagRise;
  logic                 embedded;
  logic [HC_W-1:0]      hLast;
  logic                 hAtEnd;
  logic [V_W:0]         vNext;
  logic                 vOver;

  always_comb begin
    flagVec         = '0;
    flagVec[FLAG_H] = hFlag;
    flagVec[FLAG_F] = fFlag;
  end

  vtsync_flag_edge #(.N(NUM_FLAGS)) u_edge (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (flagValid),
    .flags    (flagVec),
    .rise     (flagRise)
  );

  assign embedded = isEmbeddedFmt(fmtSel);
  assign hLast    = {pixPerLine, 1'b0} - HC_W'(1);
  assign hAtEnd   = (hCount >= hLast);
  assign vNext    = {1'b0, vCount} + (V_W + 1)'(2);
  assign vOver    = (vNext >= {1'b0, halfLinesPerFrame});

  always_comb begin
    ctrl.hLoad = embedded & flagRise[FLAG_H];
    ctrl.vLoad = embedded & flagRise[FLAG_F];
    ctrl.hWrap = hAtEnd & ~ctrl.hLoad;
    ctrl.vWrap = ctrl.hWrap & ~ctrl.vLoad & vOver;
    ctrl.vStep = ctrl.hWrap & ~ctrl.vLoad & ~vOver;
  end

endmodule

// File: rtl/vtsync_datapath.sv
module vtsync_datapath
  import vtsync_pkg::*;
#(
  parameter  int PIX_W = 10,
  parameter  int V_W   = 11,
  localparam int HC_W  = PIX_W + 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  syncCtrl_t       ctrl,
  input  logic [HC_W-1:0] hTrig,
  input  logic [V_W-1:0]  vTrig,
  output logic [HC_W-1:0] hCount,
  output logic [V_W-1:0]  vCount,
  output logic            fieldEven,
  output logic            lineStart,
  output logic            fieldStart
);

  logic [HC_W-1:0] hCountNext;
  logic [V_W-1:0]  vCountNext;
  logic            fieldNext;

  always_comb begin
    if (ctrl.hLoad)      hCountNext = hTrig;
    else if (ctrl.hWrap) hCountNext = '0;
    else                 hCountNext = hCount + HC_W'(1);
  end

  always_comb begin
    vCountNext = vCount;
    fieldNext  = fieldEven;
    if (ctrl.vLoad) begin
      vCountNext = vTrig;
      fieldNext  = 1'b1;
    end else if (ctrl.vWrap) begin
      vCountNext = '0;
      fieldNext  = ~fieldEven;
    end else if (ctrl.vStep) begin
      vCountNext = vCount + V_W'(2);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hCount    <= '0;
      vCount    <= '0;
      fieldEven <= 1'b0;
    end else begin
      hCount    <= hCountNext;
      vCount    <= vCountNext;
      fieldEven <= fieldNext;
    end
  end

  assign lineStart  = (hCount == '0);
  assign fieldStart = lineStart & (vCount == '0);

endmodule

// File: rtl/tv_timebase_sync.sv
module tv_timebase_sync
  import vtsync_pkg::*;
#(
  parameter  int PIX_W = 10,
  parameter  int V_W   = 11,
  localparam int HC_W  = PIX_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [3:0]       fmtSel,
  input  logic [PIX_W-1:0] pixPerLine,
  input  logic [V_W-1:0]   halfLinesPerFrame,
  input  logic [HC_W-1:0]  hTrig,
  input  logic [V_W-1:0]   vTrig,
  input  logic             flagValid,
  input  logic             fFlag,
  input  logic             hFlag,
  output logic [HC_W-1:0]  hCount,
  output logic [V_W-1:0]   vCount,
  output logic             fieldEven,
  output logic             lineStart,
  output logic             fieldStart
);

  syncCtrl_t ctrl;

  vtsync_ctrl #(.PIX_W(PIX_W), .V_W(V_W)) u_ctrl (
    .clk               (clk),
    .rstN              (rstN),
    .fmtSel            (fmtSel),
    .pixPerLine        (pixPerLine),
    .halfLinesPerFrame (halfLinesPerFrame),
    .flagValid         (flagValid),
    .fFlag             (fFlag),
    .hFlag             (hFlag),
    .hCount            (hCount),
    .vCount            (vCount),
    .ctrl              (ctrl)
  );

  vtsync_datapath #(.PIX_W(PIX_W), .V_W(V_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctrl       (ctrl),
    .hTrig      (hTrig),
    .vTrig      (vTrig),
    .hCount     (hCount),
    .vCount     (vCount),
    .fieldEven  (fieldEven),
    .lineStart  (lineStart),
    .fieldStart (fieldStart)
  );

endmodule

// File: rtl/tv_timebase_sync_chk.sv
module tv_timebase_sync_chk
  import vtsync_pkg::*;
#(
  parameter  int PIX_W = 10,
  parameter  int V_W   = 11,
  localparam int HC_W  = PIX_W + 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [3:0]       fmtSel,
  input logic [PIX_W-1:0] pixPerLine,
  input logic [V_W-1:0]   halfLinesPerFrame,
  input logic [HC_W-1:0]  hTrig,
  input logic [V_W-1:0]   vTrig,
  input logic [HC_W-1:0]  hCount,
  input logic [V_W-1:0]   vCount,
  input logic             fieldEven,
  input logic             lineStart,
  input logic             fieldStart,
  input syncCtrl_t        ctrl
);

  logic [HC_W:0] lineHalves;
  logic [V_W:0]  vPlusTwo;
  assign lineHalves = {1'b0, pixPerLine, 1'b0};
  assign vPlusTwo   = {1'b0, vCount} + (V_W + 1)'(2);

  AST_H_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.hLoad |=> hCount == $past(hTrig)); // R7

  AST_H_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.hLoad && ({1'b0, hCount} + (HC_W + 1)'(1) < lineHalves)) |=> hCount == $past(hCount) + HC_W'(1)); // R2

  AST_H_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.hLoad && ({1'b0, hCount} + (HC_W + 1)'(1) >= lineHalves) && pixPerLine != '0) |=> hCount == '0); // R2

  AST_V_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrl.vLoad && !ctrl.hWrap) |=> $stable(vCount) && $stable(fieldEven)); // R3

  AST_V_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.hWrap && !ctrl.vLoad && vPlusTwo >= {1'b0, halfLinesPerFrame}) |=> (vCount == '0) && (fieldEven != $past(fieldEven))); // R4

  AST_NO_LOAD_OFF_FMT: assert property (@(posedge clk) disable iff (!rstN)
    !isEmbeddedFmt(fmtSel) |-> !ctrl.hLoad && !ctrl.vLoad); // R5

  AST_V_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.vLoad |=> (vCount == $past(vTrig)) && fieldEven); // R6

  AST_NO_H_WRAP_ON_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.hLoad |-> !ctrl.hWrap && !ctrl.vStep && !ctrl.vWrap); // R7

  AST_LINE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (lineStart && !ctrl.hLoad && pixPerLine != '0) |=> !lineStart); // R9

  AST_FIELD_IN_LINE: assert property (@(posedge clk) disable iff (!rstN)
    fieldStart |-> lineStart && (vCount == '0)); // R9

endmodule

bind tv_timebase_sync tv_timebase_sync_chk #(.PIX_W(PIX_W), .V_W(V_W)) u_chk (
  .clk               (clk),
  .rstN              (rstN),
  .fmtSel            (fmtSel),
  .pixPerLine        (pixPerLine),
  .halfLinesPerFrame (halfLinesPerFrame),
  .hTrig             (hTrig),
  .vTrig             (vTrig),
  .hCount            (hCount),
  .vCount            (vCount),
  .fieldEven         (fieldEven),
  .lineStart         (lineStart),
  .fieldStart        (fieldStart),
  .ctrl              (ctrl)
);

// File: tb/tv_timebase_sync_tb.sv
module tv_timebase_sync_tb;

  localparam int PIX_W = 10;
  localparam int V_W   = 11;
  localparam int HC_W  = PIX_W + 1;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [3:0]       fmtSel = 4'd0;
  logic [PIX_W-1:0] pixPerLine = PIX_W'(6);
  logic [V_W-1:0]   halfLinesPerFrame = V_W'(10);
  logic [HC_W-1:0]  hTrig = HC_W'(5);
  logic [V_W-1:0]   vTrig = V_W'(4);
  logic             flagValid = 1'b0;
  logic             fFlag = 1'b0;
  logic             hFlag = 1'b0;
  logic [HC_W-1:0]  hCount;
  logic [V_W-1:0]   vCount;
  logic             fieldEven;
  logic             lineStart;
  logic             fieldStart;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  int  mH = 0, mV = 0;
  bit  mField = 0, mPrevF = 0, mPrevH = 0;

  always #4 clk = ~clk;

  tv_timebase_sync #(.PIX_W(PIX_W), .V_W(V_W)) u_dut (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel), .pixPerLine(pixPerLine),
    .halfLinesPerFrame(halfLinesPerFrame), .hTrig(hTrig), .vTrig(vTrig),
    .flagValid(flagValid), .fFlag(fFlag), .hFlag(hFlag),
    .hCount(hCount), .vCount(vCount), .fieldEven(fieldEven),
    .lineStart(lineStart), .fieldStart(fieldStart)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced at every rising edge
  always @(posedge clk) begin
    bit emb, fr, hr, wrap;
    int last;
    if (!rstN) begin
      mH = 0; mV = 0; mField = 0; mPrevF = 0; mPrevH = 0;
    end else begin
      emb  = (fmtSel == 4'd12) || (fmtSel == 4'd13);
      fr   = emb && flagValid && fFlag && !mPrevF;
      hr   = emb && flagValid && hFlag && !mPrevH;
      if (flagValid) begin
        mPrevF = fFlag;
        mPrevH = hFlag;
      end
      last = 2 * int'(pixPerLine) - 1;
      wrap = !hr && (mH >= last);
      if (fr) begin
        mV = int'(vTrig);
        mField = 1;
      end else if (wrap) begin
        if (mV + 2 >= int'(halfLinesPerFrame)) begin
          mV = 0;
          mField = !mField;
        end else begin
          mV = mV + 2;
        end
      end
      if (hr)        mH = int'(hTrig);
      else if (wrap) mH = 0;
      else           mH = mH + 1;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(int'(hCount) == mH, "R2 hCount", int'(hCount), mH);
      chk(int'(vCount) == mV, "R3 vCount", int'(vCount), mV);
      chk(fieldEven == mField, "R4 fieldEven", int'(fieldEven), int'(mField));
      chk(lineStart == (mH == 0), "R9 lineStart", int'(lineStart), int'(mH == 0));
      chk(fieldStart == (mH == 0 && mV == 0), "R9 fieldStart", int'(fieldStart), int'(mH == 0 && mV == 0));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    int prevH;
    cyc(3);
    // R1: reset state
    chk(hCount == '0, "R1 hCount", int'(hCount), 0);
    chk(vCount == '0, "R1 vCount", int'(vCount), 0);
    chk(fieldEven == 1'b0, "R1 fieldEven", int'(fieldEven), 0);
    rstN = 1'b1;
    cyc(1);
    chk(hCount == HC_W'(1), "R2 first step", int'(hCount), 1);
    cyc(300);

    // R5: flags ignored outside embedded formats
    fmtSel = 4'd0;
    prevH = int'(hCount);
    flagValid = 1'b1; fFlag = 1'b1; hFlag = 1'b1;
    cyc(1);
    chk(int'(hCount) == ((prevH >= 11) ? 0 : prevH + 1), "R5 hCount", int'(hCount), (prevH >= 11) ? 0 : prevH + 1);
    fFlag = 1'b0; hFlag = 1'b0;
    cyc(5);

    // R7: H rise loads trigger
    fmtSel = 4'd12;
    hTrig = HC_W'(5);
    hFlag = 1'b1;
    cyc(1);
    chk(hCount == HC_W'(5), "R7 reload", int'(hCount), 5);
    // R8: flag held high loads only once
    cyc(3);
    chk(hCount == HC_W'(8), "R8 held high", int'(hCount), 8);
    hFlag = 1'b0;
    cyc(1);
    // R8: samples with flagValid low ignored
    flagValid = 1'b0; hFlag = 1'b1; hTrig = HC_W'(2);
    cyc(2);
    chk(hCount != HC_W'(2) || mH == 2, "R8 invalid sample", int'(hCount), mH);
    flagValid = 1'b1;
    cyc(1);
    chk(hCount == HC_W'(2), "R8 valid rise", int'(hCount), 2);
    hFlag = 1'b0;
    cyc(4);

    // R6: F rise loads vertical trigger and even field
    fmtSel = 4'd13;
    vTrig = V_W'(4);
    fFlag = 1'b1;
    cyc(1);
    chk(vCount == V_W'(4), "R6 vCount", int'(vCount), 4);
    chk(fieldEven == 1'b1, "R6 fieldEven", int'(fieldEven), 1);
    fFlag = 1'b0;
    cyc(40);

    // R7 boundary: trigger at the last half-pixel
    hTrig = HC_W'(11);
    hFlag = 1'b1;
    cyc(1);
    chk(hCount == HC_W'(11), "R7 end trigger", int'(hCount), 11);
    hFlag = 1'b0;
    cyc(1);
    chk(hCount == '0, "R2 wrap after trigger", int'(hCount), 0);

    // mixed pattern sweep; model comparison covers every cycle
    for (int i = 0; i < 3000; i++) begin
      case ((i / 500) % 6)
        0: fmtSel = 4'd12;
        1: fmtSel = 4'd13;
        2: fmtSel = 4'd0;
        3: fmtSel = 4'd5;
        4: fmtSel = 4'd12;
        default: fmtSel = 4'd14;
      endcase
      flagValid = (i % 3) != 0;
      fFlag = ((i / 37) % 2) == 1;
      hFlag = ((i / 7) % 2) == 1;
      hTrig = HC_W'((i / 200) % 13);
      vTrig = V_W'(((i / 300) % 5) * 2);
      cyc(1);
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule